// File: doc/BRIEF.md
# Windowed Watchdog with Reset Pulse

This block supervises an external microcontroller. Software arms the watchdog by writing 1 to an enable bit. After that it must write the bit again inside a service window. The window opens once a minimum number of milliseconds has gone by since the last restart. It closes at a timeout chosen by a 4-bit code. A service that comes before the window opens is a fault. A timeout with no service is also a fault. On a fault the block pulls its open-drain reset pin low for a fixed number of milliseconds and sets a warm-boot flag, which software can read once it is running again.

Time is measured in `ms_tick` pulses, one per millisecond. While the sleep input is high, the elapsed count stays where it is, and it carries on from that value on wake. A hard clear returns the whole watchdog to idle and never pulls the reset pin. A power-on reset holds the pin low for a fixed time after reset is released. The timeout step, the minimum window, the fault pulse length and the power-on pulse length are all parameters given in milliseconds.

Top module: `wdog_window_top`

## Requirements
- R1: A write strobe carrying value 1 while the watchdog is idle arms it, and the elapsed count starts from zero at that write.
- R2: A write of value 1 while armed, when the elapsed count is at least MIN_WIN_MS, is a valid service. It sets the elapsed count back to zero, so a full timeout is needed before the next fault.
- R3: An armed watchdog with no service faults when the elapsed count reaches STEP_MS*(code+1) ticks, for every 4-bit code from 0 to 15. Cycles without `ms_tick` do not count.
- R4: A write of value 1 while armed, when the elapsed count is below MIN_WIN_MS, faults at once.
- R5: A fault drives `rst_pull_low` high (pin low) for exactly PULSE_MS ticks and leaves the watchdog idle.
- R6: `boot_flag` goes to 1 on a fault and goes to 0 on a `flag_rd` strobe. If a fault and a read fall in the same cycle, the flag ends at 1.
- R7: While `sleep` is high, the elapsed count holds its value. After wake, the fault comes after the remaining ticks only.
- R8: `hard_clr` disarms the watchdog, clears `boot_flag` and releases the pin by the next cycle. It never starts a pulse.
- R9: The pin is held low during power-on reset and for POR_MS ticks after reset is released, counting the release cycle. `boot_flag` is 0 after reset.
- R10: A write of value 0 disarms the watchdog. Writes that arrive while a reset pulse is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hard_clr | input | 1 | Synchronous hard clear of the whole watchdog |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sleep | input | 1 | Sleep indication; freezes the elapsed count |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| tmo_code | input | 4 | Timeout code, timeout = STEP_MS*(code+1) |
| flag_rd | input | 1 | Read strobe of the boot flag; clears it |
| rst_pull_low | output | 1 | 1 = open-drain reset pin driven low |
| boot_flag | output | 1 | Warm-boot flag, set by a watchdog fault |

## Verification
A wrong elapsed count shows up at the pin as a pulse that starts one or more ticks too early or too late. The bench therefore measures the gap from arming, or from service, to the first low sample in whole cycles, for every code, and compares it with the arithmetic timeout. An off-by-one in the window comparison changes whether a service that lands exactly on MIN_WIN_MS produces a pulse on the very next cycle, so the bench sweeps the service point across the whole window. A pulse counter that is wrong changes the measured low length. A flag priority error appears on the cycle after a read that coincides with a fault.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Timeout in ticks for a 4-bit code.
  function automatic int unsigned calc_timeout(logic [3:0] code, int unsigned step_ms);
    return step_ms * (int'(code) + 1);
  endfunction

  // Service is early while the elapsed count is below the window start.
  function automatic logic is_early(int unsigned elapsed, int unsigned min_win);
    return elapsed < min_win;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdog_window_timer.sv
module wdog_window_timer
  import wdog_pkg::*;
#(
  parameter int unsigned STEP_MS    = 32,
  parameter int unsigned MIN_WIN_MS = 8,
  parameter int          TMR_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_clr,
  input  logic             ms_tick,
  input  logic             sleep,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic [3:0]       tmo_code,
  input  logic             hold,
  output logic             armed,
  output logic [TMR_W-1:0] elapsed,
  output logic             early_ev,
  output logic             late_ev,
  output logic             service_ev
);

  logic [TMR_W:0] limit;
  logic [TMR_W:0] next_cnt;
  logic           wr_ok;
  logic           service_req;
  logic           disarm_req;
  logic           count_en;

  always_comb begin
    limit       = (TMR_W+1)'(calc_timeout(tmo_code, STEP_MS));
    next_cnt    = {1'b0, elapsed} + 1'b1;
    wr_ok       = en_wr && !hold;
    service_req = wr_ok && en_val && armed;
    disarm_req  = wr_ok && !en_val;
    early_ev    = service_req && is_early(int'(elapsed), MIN_WIN_MS);
    service_ev  = service_req && !early_ev;
    count_en    = armed && ms_tick && !sleep && !hold;
    late_ev     = count_en && !service_req && !disarm_req && (next_cnt >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else if (hard_clr) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else if (early_ev || late_ev) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else if (wr_ok) begin
      armed   <= en_val;
      elapsed <= '0;
    end else if (count_en) begin
      elapsed <= next_cnt[TMR_W-1:0];
    end
  end

  assert_service_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (service_ev && !hard_clr) |=> (armed && elapsed == '0));

  assert_early_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (early_ev && !hard_clr) |=> (!armed && elapsed == '0));

  assert_sleep_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sleep && !en_wr && !hard_clr) |=> $stable(elapsed));

  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clr |=> !armed);

  assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({early_ev, late_ev, service_ev}) <= 1);

endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int unsigned POR_MS   = 50,
  parameter int unsigned PULSE_MS = 10,
  parameter int          CNT_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_clr,
  input  logic ms_tick,
  input  logic fire,
  output logic pin_low,
  output logic busy
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain <= CNT_W'(POR_MS);
    else if (hard_clr)
      remain <= '0;
    else if (fire)
      remain <= CNT_W'(PULSE_MS);
    else if (ms_tick && remain != '0)
      remain <= remain - 1'b1;
  end

  assign busy    = (remain != '0);
  assign pin_low = busy || !rst_n;

  assert_fire_pulls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hard_clr) |=> pin_low);

  assert_clear_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clr |=> !pin_low);

  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ms_tick && !fire && !hard_clr) |=> busy);

endmodule

// File: rtl/wdog_boot_flag.sv
module wdog_boot_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_clr,
  input  logic fire,
  input  logic rd,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hard_clr) flag <= 1'b0;
    else if (fire)     flag <= 1'b1;
    else if (rd)       flag <= 1'b0;
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hard_clr) |=> flag);

  assert_flag_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !fire) |=> !flag);

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
  import wdog_pkg::*;
#(
  parameter int unsigned STEP_MS    = 32,
  parameter int unsigned MIN_WIN_MS = 8,
  parameter int unsigned PULSE_MS   = 10,
  parameter int unsigned POR_MS     = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hard_clr,
  input  logic       ms_tick,
  input  logic       sleep,
  input  logic       en_wr,
  input  logic       en_val,
  input  logic [3:0] tmo_code,
  input  logic       flag_rd,
  output logic       rst_pull_low,
  output logic       boot_flag
);

  localparam int TMR_W = $clog2(STEP_MS * 16 + 1);
  localparam int CNT_W = $clog2(max_u(POR_MS, PULSE_MS) + 1);

  logic             armed;
  logic [TMR_W-1:0] elapsed;
  logic             early_ev;
  logic             late_ev;
  logic             service_ev;
  logic             fire;
  logic             busy;

  assign fire = early_ev || late_ev;

  wdog_window_timer #(
    .STEP_MS   (STEP_MS),
    .MIN_WIN_MS(MIN_WIN_MS),
    .TMR_W     (TMR_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hard_clr  (hard_clr),
    .ms_tick   (ms_tick),
    .sleep     (sleep),
    .en_wr     (en_wr),
    .en_val    (en_val),
    .tmo_code  (tmo_code),
    .hold      (busy),
    .armed     (armed),
    .elapsed   (elapsed),
    .early_ev  (early_ev),
    .late_ev   (late_ev),
    .service_ev(service_ev)
  );

  wdog_pulse_gen #(
    .POR_MS  (POR_MS),
    .PULSE_MS(PULSE_MS),
    .CNT_W   (CNT_W)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .hard_clr(hard_clr),
    .ms_tick (ms_tick),
    .fire    (fire),
    .pin_low (rst_pull_low),
    .busy    (busy)
  );

  wdog_boot_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .hard_clr(hard_clr),
    .fire    (fire),
    .rd      (flag_rd),
    .flag    (boot_flag)
  );

  assert_idle_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed);

  assert_fire_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> armed);

endmodule

// File: tb/wdog_window_top_tb.sv
module wdog_window_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STEP   = 4;
  localparam int MINW   = 3;
  localparam int PULSE  = 5;
  localparam int PORL   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hard_clr = 1'b0;
  logic ms_tick = 1'b1;
  logic sleep = 1'b0;
  logic en_wr = 1'b0;
  logic en_val = 1'b0;
  logic [3:0] tmo_code = 4'd0;
  logic flag_rd = 1'b0;
  logic rst_pull_low;
  logic boot_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_window_top #(
    .STEP_MS(STEP), .MIN_WIN_MS(MINW), .PULSE_MS(PULSE), .POR_MS(PORL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hard_clr(hard_clr), .ms_tick(ms_tick),
    .sleep(sleep), .en_wr(en_wr), .en_val(en_val), .tmo_code(tmo_code),
    .flag_rd(flag_rd), .rst_pull_low(rst_pull_low), .boot_flag(boot_flag)
  );

  function automatic int exp_tmo(int code);
    return STEP * code + STEP;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    en_wr = 1'b1; en_val = 1'b1;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic write_en(bit v);
    en_wr = 1'b1; en_val = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!rst_pull_low && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (rst_pull_low && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(int cycles, string req);
    int highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!rst_pull_low) highs++;
    end
    chk(req, highs, cycles);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    // R9: pin low during reset, flag clear
    chk("R9 pin during reset", int'(rst_pull_low), 1);
    chk("R9 flag after reset", int'(boot_flag), 0);
    rst_n = 1'b1;
    low_len(n);
    chk("R9 power-on pulse length", n, PORL);

    // R1 R3 R5: timeout for every code, and pulse length
    for (int c = 0; c < 16; c++) begin
      tmo_code = 4'(c);
      arm();
      measure(n);
      chk("R3 timeout per code", n, exp_tmo(c));
      chk("R6 flag set by fault", int'(boot_flag), 1);
      low_len(n);
      chk("R5 fault pulse length", n, PULSE);
      flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
      chk("R6 read clears flag", int'(boot_flag), 0);
    end

    // R2 R4: sweep the service point across the whole timeout
    tmo_code = 4'd2;
    for (int k = 0; k < exp_tmo(2); k++) begin
      arm();
      repeat (k) @(negedge clk);
      write_en(1'b1);
      if (k < MINW) begin
        chk("R4 early service faults", int'(rst_pull_low), 1);
        low_len(n);
      end else begin
        chk("R2 service in window no fault", int'(rst_pull_low), 0);
        measure(n);
        chk("R2 full timeout after service", n, exp_tmo(2));
        low_len(n);
      end
    end

    // R3: no tick, no count
    tmo_code = 4'd0;
    arm();
    ms_tick = 1'b0;
    quiet(30, "R3 no count without tick");
    ms_tick = 1'b1;
    measure(n);
    chk("R3 timeout after tick resumes", n, exp_tmo(0));
    low_len(n);

    // R6: fault and read in same cycle, flag ends 1
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
    arm();
    flag_rd = 1'b1; write_en(1'b1); flag_rd = 1'b0;
    chk("R6 fault wins over read", int'(boot_flag), 1);
    low_len(n);

    // R7: sleep freezes count
    tmo_code = 4'd1;
    arm();
    repeat (2) @(negedge clk);
    sleep = 1'b1;
    quiet(40, "R7 no fault while asleep");
    sleep = 1'b0;
    measure(n);
    chk("R7 remaining ticks after wake", n, exp_tmo(1) - 2);
    low_len(n);

    // R8: hard clear mid-pulse and while armed
    tmo_code = 4'd0;
    arm();
    measure(n);
    hard_clr = 1'b1; @(negedge clk); hard_clr = 1'b0;
    chk("R8 pin released by clear", int'(rst_pull_low), 0);
    chk("R8 flag cleared by clear", int'(boot_flag), 0);
    quiet(20, "R8 idle after clear");
    arm();
    hard_clr = 1'b1; @(negedge clk); hard_clr = 1'b0;
    quiet(20, "R8 clear disarms");
    chk("R8 no flag from clear", int'(boot_flag), 0);

    // R10: write 0 disarms; writes during pulse ignored
    arm();
    @(negedge clk);
    write_en(1'b0);
    quiet(20, "R10 write zero disarms");
    arm();
    measure(n);
    write_en(1'b1);
    low_len(n);
    chk("R10 pulse unaffected by write", n, PULSE - 1);
    quiet(20, "R10 write in pulse ignored");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule